// File: doc/BRIEF.md
# Read-Pointer Sync Interrupt Controller

This block raises host interrupts that let software line up audio and video playback. It watches the read pointers of an audio and a video channel buffer. For each channel, the host can switch on a compare mode and program a 24-bit preset. When the pointer reaches the preset, the block does not interrupt right away. The match arms a per-channel hunter, which then scans the bytes that leave that channel's buffer for the channel's sync pattern. A status bit is set, and the interrupt can go low, only when that pattern appears.

The block also turns event strobes from a packet preparser into status bits. All status bits share one mask register and are cleared when the host reads them. Each outgoing byte stream is a valid/ready pair owned by the buffer and its consumer. The block only taps it. It never drives ready and never applies back-pressure, and it counts a byte only in a cycle where valid and ready are both high. The host side is a plain byte-wide register port. A write takes effect at the clock edge where `host_wr` is high. A read returns its data on `host_rdata` after the edge where `host_rd` is high.

Top module: `sync_irq_ctrl`

## Requirements
- R1: Control register at address 0: bit 0 enables video compare, and bits 2:1 form the audio compare field (any nonzero value enables it). With a channel's compare disabled, a pointer match arms nothing.
- R2: The audio preset is written at addresses 3, 4 and 5 (low, middle, high byte) and the video preset at addresses 6, 7 and 8. Writing the low or middle byte only stages it. The whole 24-bit value becomes the compare value at the write of the high byte.
- R3: A compare pulse lasts exactly one cycle, once per onset of equality. A pointer that stays equal gives no further pulse.
- R4: A pointer match alone sets no status bit. After a match, the audio hunter sets status bit 5 on a byte 0xFF followed by a byte whose upper nibble is 0xF. The video hunter sets status bit 6 on the bytes 00 00 01 00. Only bytes transferred after arming count.
- R5: `irq_n` is low exactly while some status bit is set and its mask bit (address 2, same bit positions, 1 = masked) is clear. A mask write changes `irq_n` from the next cycle.
- R6: A read of the status register (address 1) returns its value and clears every bit.
- R7: Preparser strobes set status bit 0 (audio packet), bit 1 (video packet) and bit 3 (video sequence end).
- R8: An event in the same cycle as a status read leaves its bit set after the read.
- R9: Writes to the status address change nothing. Reserved status bits 2, 4 and 7 read as 0.
- R10: After it sets its status bit, a hunter goes idle. Further sync patterns set nothing until a new pointer match.
- R11: A byte offered with valid high but ready low is not seen by the hunter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid after the read edge |
| a_rptr | input | 24 | Audio buffer read pointer |
| v_rptr | input | 24 | Video buffer read pointer |
| a_valid | input | 1 | Audio outgoing byte valid |
| a_ready | input | 1 | Audio consumer ready |
| a_data | input | 8 | Audio outgoing byte |
| v_valid | input | 1 | Video outgoing byte valid |
| v_ready | input | 1 | Video consumer ready |
| v_data | input | 8 | Video outgoing byte |
| pp_aud_pkt | input | 1 | Preparser audio packet strobe |
| pp_vid_pkt | input | 1 | Preparser video packet strobe |
| pp_seq_end | input | 1 | Preparser video sequence-end strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check several rules on every cycle. A compare pulse never lasts two cycles, and a disabled compare never pulses. A hunter reports only from its armed state and then falls idle. A read clears the status unless an event arrives with it, and an event in the cycle before is always found set.

Other behaviours need the bench's scenarios, because they depend on ordered host and stream traffic. These are the staged preset commit, the exact byte patterns that do and do not hit, the ignoring of non-handshaken bytes, mask timing on `irq_n`, and the read/event collision.

// File: rtl/sync_irq_pkg.sv
package sync_irq_pkg;
  localparam int PTR_W  = 24;
  localparam int BYTE_W = 8;
  localparam int N_CH   = 2;

  localparam logic [3:0] REG_CTRL = 4'd0;
  localparam logic [3:0] REG_STAT = 4'd1;
  localparam logic [3:0] REG_MASK = 4'd2;
  localparam logic [3:0] REG_PRE_BASE = 4'd3;
  localparam int PRE_STRIDE = 3;

  localparam int ST_APKT  = 0;
  localparam int ST_VPKT  = 1;
  localparam int ST_SEQE  = 3;
  localparam int ST_ASYNC = 5;
  localparam int ST_VSYNC = 6;
  localparam logic [7:0] ST_LIVE = 8'b0110_1011;

  typedef enum logic {HUNT_IDLE, HUNT_ARMED} hunt_e;
endpackage

// File: rtl/ptr_cmp.sv
module ptr_cmp
  import sync_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PTR_W-1:0] rptr,
  input  logic [PTR_W-1:0] preset,
  output logic             pulse
);
  logic hit_now, hit_q;
  assign hit_now = en && (rptr == preset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      pulse <= 1'b0;
    end else begin
      hit_q <= hit_now;
      pulse <= hit_now && !hit_q;
    end
  end

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  assert_no_pulse_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !pulse);
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
  import sync_irq_pkg::*;
#(
  parameter bit IS_VIDEO = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              s_valid,
  input  logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  output logic              found
);
  localparam logic [BYTE_W-1:0] HIST_INIT = IS_VIDEO ? 8'hFF : 8'h00;

  hunt_e st;
  logic [BYTE_W-1:0] h0, h1, h2;
  logic beat, pat;
  assign beat = s_valid && s_ready;

  generate
    if (IS_VIDEO) begin : g_pic
      assign pat = (h2 == 8'h00) && (h1 == 8'h00) && (h0 == 8'h01) && (s_data == 8'h00);
    end else begin : g_aud
      assign pat = (h0 == 8'hFF) && (s_data[7:4] == 4'hF);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= HUNT_IDLE;
      h0    <= HIST_INIT;
      h1    <= HIST_INIT;
      h2    <= HIST_INIT;
      found <= 1'b0;
    end else begin
      found <= 1'b0;
      if (arm) begin
        st <= HUNT_ARMED;
        h0 <= HIST_INIT;
        h1 <= HIST_INIT;
        h2 <= HIST_INIT;
      end else if (st == HUNT_ARMED && beat) begin
        h2 <= h1;
        h1 <= h0;
        h0 <= s_data;
        if (pat) begin
          found <= 1'b1;
          st    <= HUNT_IDLE;
        end
      end
    end
  end

  assert_found_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ($past(st) == HUNT_ARMED));
  assert_idle_after_found_R10: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (st == HUNT_IDLE || $past(arm)));
endmodule

// File: rtl/irq_status.sv
module irq_status
  import sync_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  evt,
  input  logic        rd_clr,
  input  logic [7:0]  mask,
  output logic [7:0]  status,
  output logic        irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= ((status & ~{8{rd_clr}}) | evt) & ST_LIVE;
  end

  assign irq_n = ~|(status & ~mask);

  assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & ST_LIVE)) |=> ((status & $past(evt & ST_LIVE)) == $past(evt & ST_LIVE)));
  assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && evt == 8'h00) |=> (status == 8'h00));
endmodule

// File: rtl/sync_irq_ctrl.sv
module sync_irq_ctrl
  import sync_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [PTR_W-1:0]  a_rptr,
  input  logic [PTR_W-1:0]  v_rptr,
  input  logic              a_valid,
  input  logic              a_ready,
  input  logic [BYTE_W-1:0] a_data,
  input  logic              v_valid,
  input  logic              v_ready,
  input  logic [BYTE_W-1:0] v_data,
  input  logic              pp_aud_pkt,
  input  logic              pp_vid_pkt,
  input  logic              pp_seq_end,
  output logic              irq_n
);
  logic [2:0] ctrl;
  logic [7:0] mask;
  logic [7:0] status;
  logic [7:0] evt;
  logic       rd_clr;

  logic [N_CH-1:0]   cmp_en, pulse, found;
  logic [PTR_W-1:0]  rptr_c   [N_CH];
  logic [PTR_W-1:0]  active_c [N_CH];
  logic [BYTE_W-1:0] lo_c     [N_CH];
  logic [BYTE_W-1:0] mid_c    [N_CH];
  logic [N_CH-1:0]   valid_c, ready_c;
  logic [BYTE_W-1:0] data_c   [N_CH];

  assign cmp_en  = {ctrl[0], |ctrl[2:1]};
  assign rptr_c[0] = a_rptr;
  assign rptr_c[1] = v_rptr;
  assign valid_c = {v_valid, a_valid};
  assign ready_c = {v_ready, a_ready};
  assign data_c[0] = a_data;
  assign data_c[1] = v_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
    end else if (host_wr) begin
      if (host_addr == REG_CTRL) ctrl <= host_wdata[2:0];
      if (host_addr == REG_MASK) mask <= host_wdata;
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < N_CH; ch++) begin : g_ch
      localparam logic [3:0] A_LO  = REG_PRE_BASE + 4'(PRE_STRIDE * ch);
      localparam logic [3:0] A_MID = A_LO + 4'd1;
      localparam logic [3:0] A_HI  = A_LO + 4'd2;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_c[ch]     <= '0;
          mid_c[ch]    <= '0;
          active_c[ch] <= '0;
        end else if (host_wr) begin
          if (host_addr == A_LO)  lo_c[ch]  <= host_wdata;
          if (host_addr == A_MID) mid_c[ch] <= host_wdata;
          if (host_addr == A_HI)  active_c[ch] <= {host_wdata, mid_c[ch], lo_c[ch]};
        end
      end

      ptr_cmp u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cmp_en[ch]),
        .rptr   (rptr_c[ch]),
        .preset (active_c[ch]),
        .pulse  (pulse[ch])
      );

      sync_hunter #(.IS_VIDEO(ch == 1)) u_hunt (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (pulse[ch]),
        .s_valid (valid_c[ch]),
        .s_ready (ready_c[ch]),
        .s_data  (data_c[ch]),
        .found   (found[ch])
      );
    end
  endgenerate

  always_comb begin
    evt = '0;
    evt[ST_APKT]  = pp_aud_pkt;
    evt[ST_VPKT]  = pp_vid_pkt;
    evt[ST_SEQE]  = pp_seq_end;
    evt[ST_ASYNC] = found[0];
    evt[ST_VSYNC] = found[1];
  end

  assign rd_clr = host_rd && (host_addr == REG_STAT);

  irq_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .rd_clr (rd_clr),
    .mask   (mask),
    .status (status),
    .irq_n  (irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) begin
      case (host_addr)
        4'd0:    host_rdata <= {5'b0, ctrl};
        4'd1:    host_rdata <= status;
        4'd2:    host_rdata <= mask;
        4'd3:    host_rdata <= lo_c[0];
        4'd4:    host_rdata <= mid_c[0];
        4'd5:    host_rdata <= active_c[0][PTR_W-1 -: 8];
        4'd6:    host_rdata <= lo_c[1];
        4'd7:    host_rdata <= mid_c[1];
        4'd8:    host_rdata <= active_c[1][PTR_W-1 -: 8];
        default: host_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: tb/tb_sync_irq_ctrl.sv
module tb_sync_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_addr = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [23:0] a_rptr = 24'hFFFFFF, v_rptr = 24'hFFFFFF;
  logic a_valid = 1'b0, a_ready = 1'b0, v_valid = 1'b0, v_ready = 1'b0;
  logic [7:0] a_data = '0, v_data = '0;
  logic pp_aud_pkt = 1'b0, pp_vid_pkt = 1'b0, pp_seq_end = 1'b0;
  logic irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sync_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .a_rptr(a_rptr), .v_rptr(v_rptr), .a_valid(a_valid), .a_ready(a_ready),
    .a_data(a_data), .v_valid(v_valid), .v_ready(v_ready), .v_data(v_data),
    .pp_aud_pkt(pp_aud_pkt), .pp_vid_pkt(pp_vid_pkt), .pp_seq_end(pp_seq_end),
    .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic send(input bit vid, input logic [7:0] d, input bit rdy);
    @(negedge clk);
    if (vid) begin v_valid = 1'b1; v_ready = rdy; v_data = d; end
    else     begin a_valid = 1'b1; a_ready = rdy; a_data = d; end
    @(negedge clk);
    a_valid = 1'b0; a_ready = 1'b0; v_valid = 1'b0; v_ready = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(irq_n === 1'b1, "R5 irq_n after reset", irq_n, 1);
    rd(4'd1, d);
    chk(d === 8'h00, "R6 status after reset", d, 0);
  endtask

  task automatic t_preparser();
    logic [7:0] d;
    @(negedge clk); pp_aud_pkt = 1'b1; pp_seq_end = 1'b1;
    @(negedge clk); pp_aud_pkt = 1'b0; pp_seq_end = 1'b0;
    chk(irq_n === 1'b0, "R5 irq low on unmasked event", irq_n, 0);
    wr(4'd1, 8'h00);
    rd(4'd1, d);
    chk(d === 8'h09, "R7 R9 packet and seq-end bits, write ignored", d, 8'h09);
    chk(irq_n === 1'b1, "R6 irq released after read", irq_n, 1);
    rd(4'd1, d);
    chk(d === 8'h00, "R6 status cleared by read", d, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(4'd2, 8'h02);
    @(negedge clk); pp_vid_pkt = 1'b1;
    @(negedge clk); pp_vid_pkt = 1'b0;
    chk(irq_n === 1'b1, "R5 masked source holds irq high", irq_n, 1);
    wr(4'd2, 8'h00);
    chk(irq_n === 1'b0, "R5 unmask takes effect next cycle", irq_n, 0);
    wr(4'd1, 8'hFF);
    rd(4'd1, d);
    chk(d === 8'h02, "R7 R9 video packet bit, reserved read 0", d, 8'h02);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk); host_addr = 4'd1; host_rd = 1'b1; pp_vid_pkt = 1'b1;
    @(negedge clk); host_rd = 1'b0; pp_vid_pkt = 1'b0;
    chk(host_rdata === 8'h00, "R8 read returns prior value", host_rdata, 0);
    rd(4'd1, d);
    chk(d === 8'h02, "R8 event in read cycle kept", d, 8'h02);
  endtask

  task automatic t_audio();
    logic [7:0] d;
    wr(4'd3, 8'h56); wr(4'd4, 8'h34); wr(4'd5, 8'h12);
    wr(4'd0, 8'h02);
    @(negedge clk); a_rptr = 24'h123456;
    settle();
    chk(irq_n === 1'b1, "R4 match alone sets nothing", irq_n, 1);
    @(negedge clk); a_rptr = 24'h000100;
    send(1'b0, 8'hFF, 1'b0);
    send(1'b0, 8'hF0, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h00, "R11 byte without ready ignored", d, 0);
    send(1'b0, 8'hFF, 1'b1);
    send(1'b0, 8'hF3, 1'b1);
    settle();
    chk(irq_n === 1'b0, "R4 audio sync raises irq", irq_n, 0);
    rd(4'd1, d);
    chk(d === 8'h20, "R4 audio sync bit 5", d, 8'h20);
    send(1'b0, 8'hFF, 1'b1);
    send(1'b0, 8'hF0, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h00, "R10 hunter idle after report", d, 0);
  endtask

  task automatic t_partial_preset();
    logic [7:0] d;
    wr(4'd3, 8'h00);
    @(negedge clk); a_rptr = 24'h123400;
    settle();
    send(1'b0, 8'hFF, 1'b1);
    send(1'b0, 8'hF0, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h00, "R2 staged low byte does not match", d, 0);
    wr(4'd4, 8'h34); wr(4'd5, 8'h12);
    settle();
    send(1'b0, 8'hFF, 1'b1);
    send(1'b0, 8'hF0, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h20, "R2 commit on high byte arms", d, 8'h20);
    @(negedge clk); a_rptr = 24'h000100;
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(4'd0, 8'h00);
    @(negedge clk); a_rptr = 24'h123400;
    settle();
    send(1'b0, 8'hFF, 1'b1);
    send(1'b0, 8'hF0, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h00, "R1 compare disabled arms nothing", d, 0);
    @(negedge clk); a_rptr = 24'h000100;
  endtask

  task automatic t_video();
    logic [7:0] d;
    wr(4'd6, 8'hCD); wr(4'd7, 8'hAB); wr(4'd8, 8'h00);
    wr(4'd0, 8'h01);
    @(negedge clk); v_rptr = 24'h00ABCD;
    settle();
    @(negedge clk); v_rptr = 24'h000200;
    send(1'b1, 8'h00, 1'b1); send(1'b1, 8'h00, 1'b1);
    send(1'b1, 8'h01, 1'b1); send(1'b1, 8'hB3, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h00, "R4 sequence header is not picture start", d, 0);
    send(1'b1, 8'h00, 1'b1); send(1'b1, 8'h00, 1'b1);
    send(1'b1, 8'h01, 1'b1); send(1'b1, 8'h00, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h40, "R4 picture start sets bit 6", d, 8'h40);
  endtask

  task automatic t_hold_pointer();
    logic [7:0] d;
    @(negedge clk); v_rptr = 24'h00ABCD;
    settle();
    send(1'b1, 8'h00, 1'b1); send(1'b1, 8'h00, 1'b1);
    send(1'b1, 8'h01, 1'b1); send(1'b1, 8'h00, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h40, "R3 first onset arms once", d, 8'h40);
    send(1'b1, 8'h00, 1'b1); send(1'b1, 8'h00, 1'b1);
    send(1'b1, 8'h01, 1'b1); send(1'b1, 8'h00, 1'b1);
    settle();
    rd(4'd1, d);
    chk(d === 8'h00, "R3 steady pointer gives no second pulse", d, 0);
    @(negedge clk); v_rptr = 24'h000200;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preparser();
    t_mask();
    t_collision();
    t_audio();
    t_partial_preset();
    t_disabled();
    t_video();
    t_hold_pointer();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule